// File: doc/BRIEF.md
# Precision Time Counter

This block keeps the local time of a time-synchronised node. It holds a 32-bit seconds count and a 32-bit sub-second count, both advanced by one clock. Each advance adds a programmable 8-bit step to the sub-second count. In coarse mode an advance happens on every clock. In fine mode an advance happens only when a 32-bit phase accumulator, which adds a programmable addend each clock, carries out of its top bit. A servo outside the block can therefore trim the rate of time by changing the addend alone.

The sub-second count wraps at one of two limits, chosen by a mode input. The binary limit is 2^31, so the count wraps after 0x7FFFFFFF. The decimal limit is 10^9, so the count wraps after 999,999,999 and holds whole nanoseconds. Every wrap adds one to the seconds count and raises a one-cycle pulse.

Two commands change the time directly:
- A load command writes an absolute time.
- An adjust command adds a signed offset, given as a sign, a seconds part and a sub-second part. It carries into or borrows from the seconds count as needed.

Each command is latched on the edge that accepts it and applied whole on the next edge, and a done pulse follows. A read strobe copies both counts into a snapshot pair on the same edge, so a reader never sees a torn value.

Top module: `ptp_time_counter`

## Requirements
- R1: While `rst_n` is low, every output is zero. The counter first advances on the third rising edge after `rst_n` rises: the internal reset is released on the second edge, and the counter is still held on that edge.
- R2: With `fine_mode`=0, the sub-second count grows by `step_inc` on every clock edge that applies no command.
- R3: With `fine_mode`=1, a 32-bit accumulator, cleared by reset, adds `addend` on every edge. The sub-second count grows by `step_inc` only on an edge where that addition carries out of bit 31. With `addend`=0x80000000 this happens on every second edge.
- R4: With `digital_mode`=0, when the sub-second count plus the step reaches 2^31, the sum minus 2^31 is kept, the seconds count grows by one, and `sec_pulse` is high for exactly that one cycle.
- R5: With `digital_mode`=1, the same wrap happens at 1,000,000,000 instead of 2^31.
- R6: A `set_req` accepted on edge E loads `cmd_sec` and `cmd_sub` as the time on edge E+1. No advance happens on E+1.
- R7: An accepted `adj_req` with `cmd_neg`=0 adds `cmd_sec` and `cmd_sub` to the time on edge E+1. When the sub-second sum reaches the active limit, the limit is taken off and one extra second is added. `cmd_sub` must be below the active limit.
- R8: An accepted `adj_req` with `cmd_neg`=1 subtracts the offset on edge E+1. A negative sub-second result has the limit added back and borrows one extra second. The seconds count wraps modulo 2^32.
- R9: A request is accepted only when `cmd_busy` is low. `cmd_busy` is high for exactly one cycle after acceptance, and `cmd_done` is high for the cycle after that. A request made while `cmd_busy` is high has no effect. When `set_req` and `adj_req` are both high, the load wins.
- R10: Changing `addend` or `step_inc` at run time never changes the current time. It only changes how much later edges advance the time.
- R11: On every edge where `rd_strobe` is high, `snap_sec` and `snap_sub` take the values that `now_sec` and `now_sub` held just before that edge. At other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fine_mode | input | 1 | 1: advance on accumulator carry; 0: advance every clock |
| digital_mode | input | 1 | 1: wrap sub-seconds at 10^9; 0: wrap at 2^31 |
| step_inc | input | 8 | Sub-second step per advance |
| addend | input | 32 | Accumulator addend for fine mode |
| set_req | input | 1 | Request to load an absolute time |
| adj_req | input | 1 | Request to apply a signed offset |
| cmd_neg | input | 1 | Offset sign, 1 means subtract |
| cmd_sec | input | 32 | Seconds operand of a command |
| cmd_sub | input | 32 | Sub-second operand of a command |
| rd_strobe | input | 1 | Capture current time into the snapshot |
| now_sec | output | 32 | Live seconds count |
| now_sub | output | 32 | Live sub-second count |
| sec_pulse | output | 1 | One-cycle pulse on each seconds rollover |
| cmd_busy | output | 1 | A command is latched and applies on the next edge |
| cmd_done | output | 1 | One-cycle pulse after a command has been applied |
| snap_sec | output | 32 | Snapshot seconds |
| snap_sub | output | 32 | Snapshot sub-seconds |

## Verification
A wrong accumulator or step value shows up at once: `now_sub` drifts from the reference on the first edge that should have advanced it. A wrong rollover limit or a lost carry or borrow shows up on the edge of the wrap or command. There, `now_sec` is off by a second, or `now_sub` lies outside the wrap range. A fault in the command handshake shows up within two cycles, as a missing or extra `cmd_done` or an offset applied twice. The bench therefore compares every output against a reference model on every cycle, rather than only at chosen sample points.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  parameter int SEC_W = 32;
  parameter int SUB_W = 32;

  // Wrap moduli, one bit wider than the sub-second count.
  localparam logic [SUB_W:0] BIN_MOD = {2'b01, {(SUB_W-1){1'b0}}};
  localparam logic [SUB_W:0] DIG_MOD = (SUB_W+1)'(1_000_000_000);

  typedef struct packed {
    logic             load;
    logic             neg;
    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;
  } ptc_cmd_t;

  function automatic logic [SUB_W:0] wrap_mod(input logic digital);
    return digital ? DIG_MOD : BIN_MOD;
  endfunction
endpackage

// File: rtl/ptc_rst_sync.sv
module ptc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptc_tick_gen.sv
module ptc_tick_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode,
  input  logic [ACC_W-1:0] addend,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   acc_sum;

  always_comb begin
    acc_sum = {1'b0, acc_q} + {1'b0, addend};
    if (fine_mode) begin
      acc_d = acc_sum[ACC_W-1:0];
      tick  = acc_sum[ACC_W];
    end else begin
      acc_d = acc_q;
      tick  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (fine_mode) acc_q <= acc_d;
  end
endmodule

// File: rtl/ptc_cmd_stage.sv
module ptc_cmd_stage
  import ptc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic             adj_req,
  input  logic             cmd_neg,
  input  logic [SEC_W-1:0] cmd_sec,
  input  logic [SUB_W-1:0] cmd_sub,
  output logic             apply,
  output ptc_cmd_t         cmd,
  output logic             done
);
  logic     pend_q, pend_d;
  logic     done_d;
  logic     take;
  ptc_cmd_t cmd_q, cmd_d;

  always_comb begin
    take   = !pend_q && (set_req || adj_req);
    pend_d = take;
    done_d = pend_q;
    cmd_d  = cmd_q;
    if (take) begin
      cmd_d.load = set_req;
      cmd_d.neg  = cmd_neg;
      cmd_d.sec  = cmd_sec;
      cmd_d.sub  = cmd_sub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done   <= 1'b0;
      cmd_q  <= '0;
    end else begin
      pend_q <= pend_d;
      done   <= done_d;
      if (take) cmd_q <= cmd_d;
    end
  end

  assign apply = pend_q;
  assign cmd   = cmd_q;
endmodule

// File: rtl/ptc_time_core.sv
module ptc_time_core
  import ptc_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             digital_mode,
  input  logic [INC_W-1:0] step_inc,
  input  logic             tick,
  input  logic             apply,
  input  ptc_cmd_t         cmd,
  output logic [SEC_W-1:0] sec,
  output logic [SUB_W-1:0] sub,
  output logic             pulse
);
  localparam int PAD_W = SUB_W + 1 - INC_W;

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             pulse_d;
  logic [SUB_W:0]   lim, inc_sum, add_sum, dif, dif_fix;
  logic             inc_wrap, add_wrap, borrow;

  always_comb begin
    lim      = wrap_mod(digital_mode);
    inc_sum  = {1'b0, sub_q} + {{PAD_W{1'b0}}, step_inc};
    inc_wrap = inc_sum >= lim;
    add_sum  = {1'b0, sub_q} + {1'b0, cmd.sub};
    add_wrap = add_sum >= lim;
    dif      = {1'b0, sub_q} - {1'b0, cmd.sub};
    borrow   = dif[SUB_W];
    dif_fix  = dif + lim;

    sec_d   = sec_q;
    sub_d   = sub_q;
    pulse_d = 1'b0;
    if (apply) begin
      if (cmd.load) begin
        sec_d = cmd.sec;
        sub_d = cmd.sub;
      end else if (!cmd.neg) begin
        sub_d = add_wrap ? SUB_W'(add_sum - lim) : add_sum[SUB_W-1:0];
        sec_d = sec_q + cmd.sec + SEC_W'(add_wrap);
      end else begin
        sub_d = borrow ? dif_fix[SUB_W-1:0] : dif[SUB_W-1:0];
        sec_d = sec_q - cmd.sec - SEC_W'(borrow);
      end
    end else if (tick) begin
      sub_d   = inc_wrap ? SUB_W'(inc_sum - lim) : inc_sum[SUB_W-1:0];
      sec_d   = sec_q + SEC_W'(inc_wrap);
      pulse_d = inc_wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
      pulse <= 1'b0;
    end else begin
      sec_q <= sec_d;
      sub_q <= sub_d;
      pulse <= pulse_d;
    end
  end

  assign sec = sec_q;
  assign sub = sub_q;
endmodule

// File: rtl/ptc_snapshot.sv
module ptc_snapshot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] snap_d;

  always_comb snap_d = en ? din : dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= snap_d;
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptc_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode,
  input  logic             digital_mode,
  input  logic [INC_W-1:0] step_inc,
  input  logic [ACC_W-1:0] addend,
  input  logic             set_req,
  input  logic             adj_req,
  input  logic             cmd_neg,
  input  logic [SEC_W-1:0] cmd_sec,
  input  logic [SUB_W-1:0] cmd_sub,
  input  logic             rd_strobe,
  output logic [SEC_W-1:0] now_sec,
  output logic [SUB_W-1:0] now_sub,
  output logic             sec_pulse,
  output logic             cmd_busy,
  output logic             cmd_done,
  output logic [SEC_W-1:0] snap_sec,
  output logic [SUB_W-1:0] snap_sub
);
  localparam int SNAP_W = SEC_W + SUB_W;

  logic        rst_core_n;
  logic        tick;
  logic        apply;
  ptc_cmd_t    cmd;
  logic [SNAP_W-1:0] snap_q;

  ptc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  ptc_tick_gen #(.ACC_W(ACC_W)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .fine_mode(fine_mode),
    .addend(addend), .tick(tick)
  );

  ptc_cmd_stage u_cmd (
    .clk(clk), .rst_n(rst_core_n), .set_req(set_req), .adj_req(adj_req),
    .cmd_neg(cmd_neg), .cmd_sec(cmd_sec), .cmd_sub(cmd_sub),
    .apply(apply), .cmd(cmd), .done(cmd_done)
  );

  ptc_time_core #(.INC_W(INC_W)) u_core (
    .clk(clk), .rst_n(rst_core_n), .digital_mode(digital_mode),
    .step_inc(step_inc), .tick(tick), .apply(apply), .cmd(cmd),
    .sec(now_sec), .sub(now_sub), .pulse(sec_pulse)
  );

  ptc_snapshot #(.W(SNAP_W)) u_snap (
    .clk(clk), .rst_n(rst_core_n), .en(rd_strobe),
    .din({now_sec, now_sub}), .dout(snap_q)
  );

  assign cmd_busy = apply;
  assign snap_sec = snap_q[SNAP_W-1:SUB_W];
  assign snap_sub = snap_q[SUB_W-1:0];
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import ptc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_strobe,
  input logic [SEC_W-1:0] now_sec,
  input logic [SUB_W-1:0] now_sub,
  input logic             sec_pulse,
  input logic             cmd_busy,
  input logic             cmd_done,
  input logic [SEC_W-1:0] snap_sec,
  input logic [SUB_W-1:0] snap_sub
);
  // R9
  busy_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |=> (cmd_done && !cmd_busy));

  // R9
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |=> !cmd_done);

  // R4
  pulse_bumps_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !cmd_done) |-> (now_sec == $past(now_sec) + 1'b1));

  // R2
  sec_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !cmd_done) |-> $stable(now_sec));

  // R5
  sub_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    now_sub[SUB_W-1] == 1'b0);

  // R11
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (snap_sec == $past(now_sec) && snap_sub == $past(now_sub)));

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ($stable(snap_sec) && $stable(snap_sub)));
endmodule

bind ptp_time_counter ptc_checker u_chk (
  .clk(clk), .rst_n(rst_core_n), .rd_strobe(rd_strobe),
  .now_sec(now_sec), .now_sub(now_sub), .sec_pulse(sec_pulse),
  .cmd_busy(cmd_busy), .cmd_done(cmd_done),
  .snap_sec(snap_sec), .snap_sub(snap_sub)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fine_mode, digital_mode;
  logic [7:0]  step_inc;
  logic [31:0] addend;
  logic        set_req, adj_req, cmd_neg;
  logic [31:0] cmd_sec, cmd_sub;
  logic        rd_strobe;
  logic [31:0] now_sec, now_sub, snap_sec, snap_sub;
  logic        sec_pulse, cmd_busy, cmd_done;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    mon_on = 1'b0;

  always #2 clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode), .digital_mode(digital_mode),
    .step_inc(step_inc), .addend(addend), .set_req(set_req), .adj_req(adj_req),
    .cmd_neg(cmd_neg), .cmd_sec(cmd_sec), .cmd_sub(cmd_sub), .rd_strobe(rd_strobe),
    .now_sec(now_sec), .now_sub(now_sub), .sec_pulse(sec_pulse),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done), .snap_sec(snap_sec), .snap_sub(snap_sub)
  );

  // Reference model built from the requirements.
  logic [1:0]  m_rs;
  logic [31:0] m_sec, m_sub, m_acc, m_csec, m_csub;
  logic        m_pend, m_done, m_pulse, m_cload, m_cneg;
  longint      t_lim, t_s, t_a;
  bit          t_tk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00; m_sec <= '0; m_sub <= '0; m_acc <= '0;
      m_pend <= 1'b0; m_done <= 1'b0; m_pulse <= 1'b0;
      m_cload <= 1'b0; m_cneg <= 1'b0; m_csec <= '0; m_csub <= '0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin
        t_lim = digital_mode ? 64'd1000000000 : 64'h80000000;
        t_a   = longint'(m_acc) + longint'(addend);
        if (fine_mode) begin
          t_tk  = t_a >= 64'h100000000;
          m_acc <= t_a[31:0];
        end else t_tk = 1'b1;
        m_pulse <= 1'b0;
        m_done  <= m_pend;
        if (m_pend) begin
          m_pend <= 1'b0;
          if (m_cload) begin
            m_sec <= m_csec; m_sub <= m_csub;
          end else if (!m_cneg) begin
            t_s = longint'(m_sub) + longint'(m_csub);
            if (t_s >= t_lim) begin m_sub <= 32'(t_s - t_lim); m_sec <= m_sec + m_csec + 1; end
            else begin m_sub <= 32'(t_s); m_sec <= m_sec + m_csec; end
          end else begin
            t_s = longint'(m_sub) - longint'(m_csub);
            if (t_s < 0) begin m_sub <= 32'(t_s + t_lim); m_sec <= m_sec - m_csec - 1; end
            else begin m_sub <= 32'(t_s); m_sec <= m_sec - m_csec; end
          end
        end else begin
          if (t_tk) begin
            t_s = longint'(m_sub) + longint'(step_inc);
            if (t_s >= t_lim) begin m_sub <= 32'(t_s - t_lim); m_sec <= m_sec + 1; m_pulse <= 1'b1; end
            else m_sub <= 32'(t_s);
          end
          if (set_req || adj_req) begin
            m_pend <= 1'b1; m_cload <= set_req; m_cneg <= cmd_neg;
            m_csec <= cmd_sec; m_csub <= cmd_sub;
          end
        end
      end
    end
  end

  // Scoreboard for snapshots.
  logic [63:0] exp_q[$];
  logic        strobe_seen;
  always @(posedge clk) strobe_seen <= rd_strobe;

  always @(negedge clk) begin
    if (mon_on) begin
      n_vec++;
      if (now_sec !== m_sec || now_sub !== m_sub || sec_pulse !== m_pulse ||
          cmd_busy !== m_pend || cmd_done !== m_done) begin
        n_bad++;
        $display("FAIL %s live sec/sub/pulse/busy/done actual=%h/%h/%b/%b/%b expected=%h/%h/%b/%b/%b",
                 cur_req, now_sec, now_sub, sec_pulse, cmd_busy, cmd_done,
                 m_sec, m_sub, m_pulse, m_pend, m_done);
      end
      if (strobe_seen && exp_q.size() > 0) begin
        logic [63:0] e;
        e = exp_q.pop_front();
        n_vec++;
        if ({snap_sec, snap_sub} !== e) begin
          n_bad++;
          $display("FAIL R11 snapshot actual=%h expected=%h", {snap_sec, snap_sub}, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic snap();
    rd_strobe = 1'b1;
    exp_q.push_back({m_sec, m_sub});
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic do_set(input logic [31:0] s, input logic [31:0] ns);
    set_req = 1'b1; cmd_sec = s; cmd_sub = ns;
    @(negedge clk);
    set_req = 1'b0;
  endtask

  task automatic do_adj(input logic neg, input logic [31:0] s, input logic [31:0] ns);
    adj_req = 1'b1; cmd_neg = neg; cmd_sec = s; cmd_sub = ns;
    @(negedge clk);
    adj_req = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; fine_mode = 1'b0; digital_mode = 1'b0; step_inc = 8'd8;
    addend = 32'h8000_0000; set_req = 1'b0; adj_req = 1'b0; cmd_neg = 1'b0;
    cmd_sec = '0; cmd_sub = '0; rd_strobe = 1'b0;
    #1 rst_n = 1'b0;
    #2 mon_on = 1'b1;
    cur_req = "R1";
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    cur_req = "R2"; cyc(10); snap();
    step_inc = 8'd255; cyc(5); snap();
    cur_req = "R6"; do_set(32'd5, 32'h7FFF_FFE0); cyc(3);
    cur_req = "R4"; step_inc = 8'd16; cyc(6); snap();
    cur_req = "R5"; digital_mode = 1'b1; step_inc = 8'd7;
    do_set(32'd100, 32'd999_999_990); cyc(6); snap();
    cur_req = "R3"; fine_mode = 1'b1; step_inc = 8'd3; cyc(20); snap();
    cur_req = "R10"; addend = 32'h4000_0000; cyc(12); addend = 32'hFFFF_FFFF; cyc(8);
    step_inc = 8'd1; cyc(4); snap();
    fine_mode = 1'b0; step_inc = 8'd2;
    cur_req = "R7"; do_set(32'd10, 32'd500_000_000); cyc(2);
    do_adj(1'b0, 32'd2, 32'd999_999_999); cyc(3); snap();
    do_adj(1'b0, 32'd1, 32'd3); cyc(3);
    cur_req = "R8"; do_adj(1'b1, 32'd1, 32'd999_999_999); cyc(3);
    do_adj(1'b1, 32'd0, 32'd7); cyc(3);
    do_set(32'd0, 32'd5); cyc(2);
    do_adj(1'b1, 32'd0, 32'd10); cyc(3); snap();
    digital_mode = 1'b0;
    do_set(32'd3, 32'd4); cyc(2);
    do_adj(1'b1, 32'd1, 32'h7FFF_FFF0); cyc(3);
    do_adj(1'b0, 32'd0, 32'h7FFF_FFF0); cyc(3);
    cur_req = "R9"; do_set(32'd50, 32'd0);
    do_adj(1'b0, 32'd9, 32'd9); cyc(3);
    set_req = 1'b1; adj_req = 1'b1; cmd_neg = 1'b0; cmd_sec = 32'd77; cmd_sub = 32'd123;
    @(negedge clk); set_req = 1'b0; adj_req = 1'b0; cyc(3); snap();
    cur_req = "R11"; snap(); snap(); cyc(2); snap();
    cyc(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule